// File: doc/BRIEF.md
# Serial Clock-Chip Command Port

This block is the clock-chip end of a three-wire serial link that software drives by toggling bits in a control register. One bit enables the link, one bit is the serial clock and one bit is the serial data. The block counts falling clock edges. It assembles an 8-bit command and then an 8-bit data value, and it returns a serial data-out bit for read commands.

The command value selects the operation:

- **Reads of the 32-byte battery-backed RAM:** commands 0x00 to 0x1F return the byte at that address.
- **Writes to the RAM:** commands 0x80 to 0x9F store the data value.
- **Status read:** command 0x30 returns the status byte. Command 0x31 returns zero.
- **Time-of-day reads:** commands 0x20 to 0x2F return packed BCD time fields, which are supplied on input ports.
- **Control write:** command 0xB1 can clear two status flags and request that an interrupt flag elsewhere be cleared.

The block does no time counting of its own.

Top module: `rtc_serial_port`

## Requirements
- R1: Control bits are `ctl_bits[0]` = enable, `ctl_bits[1]` = serial clock and `ctl_bits[2]` = serial data. A bit is taken only in a cycle where enable is 1 and the clock bit goes from 1 (previous cycle) to 0. Rising edges and edges seen while enable is 0 take nothing.
- R2: The first 8 bits taken form the command, most significant bit first. The next 8 bits form the data value, most significant bit first.
- R3: Enable at 0 abandons the frame. It clears the bit count, the command and the data value, so a partial frame writes nothing and the next frame starts from bit 0.
- R4: For commands 0x00–0x1F, the 9th to 16th taken bits each update `ser_dout` on the same clock edge. The value is the addressed RAM byte, most significant bit first.
- R5: After reset, RAM byte i holds ((17·i) mod 256) XOR 0x5A and the status byte is 0x90.
- R6: Command 0x30 reads the status byte. Command 0x31 reads 0x00.
- R7: The BCD time fields are read as follows. Any other code in 0x20–0x2F reads 0x00.

  | Command | Field |
  |---|---|
  | 0x20 | seconds |
  | 0x21 | minutes |
  | 0x22 | hours |
  | 0x24 | day of month |
  | 0x25 | month |
  | 0x26 | year |

- R8: On the 16th taken bit, commands 0x80–0x9F store the data value into RAM byte (command − 0x80).
- R9: On the 16th taken bit, command 0xB1 with data bit 2 set clears status bits 3 and 4 (mask 0x18), so 0x90 becomes 0x80. It also raises `irq2_clr` for exactly one cycle. With data bit 2 clear the command has no effect.
- R10: Falling clock edges after the 16th taken bit are ignored until enable drops and rises again.
- R11: `ser_dout` is 0 while enable is 0, during the first 8 bits of a frame, and for commands that are not reads, such as writes or 0x40.
- R12: If enable drops in the same cycle as the clock falls for the 16th bit, the abort wins and no write or control action takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_bits | input | 3 | Serial link control bits: enable, clock, data |
| bcd_sec | input | 8 | Seconds, packed BCD |
| bcd_min | input | 8 | Minutes, packed BCD |
| bcd_hour | input | 8 | Hours, packed BCD |
| bcd_mday | input | 8 | Day of month, packed BCD |
| bcd_month | input | 8 | Month, packed BCD |
| bcd_year | input | 8 | Two-digit year, packed BCD |
| ser_dout | output | 1 | Serial data returned to the host |
| irq2_clr | output | 1 | One-cycle request to clear interrupt status bit 2 |

## Verification
The frame commit on the 16th falling edge and the frame abort from enable dropping can fall in the same cycle. The bench provokes this by moving the control bits from clock-high/enable-high straight to all zero on the final bit of a RAM write. It judges the outcome by reading that RAM byte back in a later frame and expecting its reset value. The same commit edge also carries the last data-out update and the interrupt-clear pulse. The bench checks the pulse width at the cycle right after that edge and checks the status byte through a following 0x30 read.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int CMD_W = 8;
  localparam int DAT_W = 8;

  typedef logic [5:0][DAT_W-1:0] rtc_time_t;

  typedef struct packed {
    logic             hit;
    logic [DAT_W-1:0] val;
  } rtc_rd_t;

  // Power-up contents of the battery RAM
  function automatic logic [DAT_W-1:0] rtc_init_byte(input int idx);
    return DAT_W'(idx * 17) ^ DAT_W'(8'h5A);
  endfunction

  function automatic logic rtc_is_ram_wr(input logic [CMD_W-1:0] cmd);
    return cmd[7:5] == 3'b100;
  endfunction

  function automatic logic rtc_is_ctrl(input logic [CMD_W-1:0] cmd);
    return cmd == 8'hB1;
  endfunction

  // Choose the byte returned for a read command
  function automatic rtc_rd_t rtc_read_sel(input logic [CMD_W-1:0] cmd,
                                           input logic [DAT_W-1:0] ram_b,
                                           input logic [DAT_W-1:0] status,
                                           input rtc_time_t        tf);
    rtc_rd_t r;
    r.hit = 1'b0;
    r.val = '0;
    if (cmd <= 8'h1F) begin
      r.hit = 1'b1;
      r.val = ram_b;
    end else if (cmd == 8'h30) begin
      r.hit = 1'b1;
      r.val = status;
    end else if (cmd == 8'h31) begin
      r.hit = 1'b1;
    end else if (cmd[7:4] == 4'h2) begin
      r.hit = 1'b1;
      case (cmd[3:0])
        4'h0: r.val = tf[0];
        4'h1: r.val = tf[1];
        4'h2: r.val = tf[2];
        4'h4: r.val = tf[3];
        4'h5: r.val = tf[4];
        4'h6: r.val = tf[5];
        default: r.val = '0;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/rtc_frame_shifter.sv
module rtc_frame_shifter #(
  parameter int CMD_W = 8,
  parameter int DAT_W = 8,
  localparam int FRAME_LEN = CMD_W + DAT_W,
  localparam int PH_W = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sclk,
  input  logic             sdin,
  output logic [PH_W-1:0]  phase_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic [DAT_W-1:0] val_next_o,
  output logic             take_o,
  output logic             last_o
);

  logic             prev_clk;
  logic [PH_W-1:0]  phase_q;
  logic [CMD_W-1:0] cmd_q;
  logic [DAT_W-2:0] val_q;

  assign take_o     = en && prev_clk && !sclk && (phase_q < PH_W'(FRAME_LEN));
  assign last_o     = take_o && (phase_q == PH_W'(FRAME_LEN - 1));
  assign val_next_o = {val_q, sdin};
  assign phase_o    = phase_q;
  assign cmd_o      = cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_clk <= 1'b0;
      phase_q  <= '0;
      cmd_q    <= '0;
      val_q    <= '0;
    end else begin
      prev_clk <= sclk;
      if (!en) begin
        phase_q <= '0;
        cmd_q   <= '0;
        val_q   <= '0;
      end else if (take_o) begin
        phase_q <= phase_q + 1'b1;
        if (phase_q < PH_W'(CMD_W)) cmd_q <= {cmd_q[CMD_W-2:0], sdin};
        else                         val_q <= {val_q[DAT_W-3:0], sdin};
      end
    end
  end

  a_r10_phase_cap: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= PH_W'(FRAME_LEN));

  a_r10_hold_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_W'(FRAME_LEN) && en) |=> phase_q == PH_W'(FRAME_LEN));

  a_r3_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (phase_q == '0 && cmd_q == '0 && val_q == '0));

  a_r1_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (phase_q == '0 || phase_q == $past(phase_q) ||
              phase_q == $past(phase_q) + 1'b1));

endmodule

// File: rtl/rtc_nvram.sv
module rtc_nvram #(
  parameter int DEPTH = 32,
  parameter int W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)                         mem[i] <= W'(rtc_pkg::rtc_init_byte(i));
      else if (we && waddr == AW'(i))     mem[i] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/rtc_status_reg.sv
module rtc_status_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RESET_VAL = 8'h90,
  parameter logic [W-1:0] CLR_MASK  = 8'h18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] status_o,
  output logic         irq_clr_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_o  <= RESET_VAL;
      irq_clr_o <= 1'b0;
    end else begin
      irq_clr_o <= clr;
      if (clr) status_o <= status_o & ~CLR_MASK;
    end
  end

  a_r9_status_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_o & ~$past(status_o)) == '0);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr_o |=> !irq_clr_o);

endmodule

// File: rtl/rtc_serial_port.sv
module rtc_serial_port #(
  parameter int RAM_DEPTH = 32,
  parameter logic [7:0] STATUS_RESET = 8'h90,
  parameter logic [7:0] STATUS_CLR_MASK = 8'h18,
  parameter int CTRL_CLR_BIT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] ctl_bits,
  input  logic [7:0] bcd_sec,
  input  logic [7:0] bcd_min,
  input  logic [7:0] bcd_hour,
  input  logic [7:0] bcd_mday,
  input  logic [7:0] bcd_month,
  input  logic [7:0] bcd_year,
  output logic       ser_dout,
  output logic       irq2_clr
);
  import rtc_pkg::*;

  localparam int FRAME_LEN = CMD_W + DAT_W;
  localparam int PH_W = $clog2(FRAME_LEN + 1);
  localparam int BI_W = $clog2(DAT_W);
  localparam int AW = $clog2(RAM_DEPTH);

  logic             en, sclk, sdin;
  logic [PH_W-1:0]  phase;
  logic [CMD_W-1:0] cmd;
  logic [DAT_W-1:0] val_next;
  logic             take, last;
  logic [DAT_W-1:0] ram_rd, status;
  logic             ram_we, ctrl_clr;
  rtc_time_t        tfields;
  rtc_rd_t          rd_sel;
  logic [BI_W-1:0]  bidx;

  assign en   = ctl_bits[0];
  assign sclk = ctl_bits[1];
  assign sdin = ctl_bits[2];
  assign tfields = {bcd_year, bcd_month, bcd_mday, bcd_hour, bcd_min, bcd_sec};

  rtc_frame_shifter #(.CMD_W(CMD_W), .DAT_W(DAT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(en), .sclk(sclk), .sdin(sdin),
    .phase_o(phase), .cmd_o(cmd), .val_next_o(val_next),
    .take_o(take), .last_o(last)
  );

  assign ram_we   = last && rtc_is_ram_wr(cmd);
  assign ctrl_clr = last && rtc_is_ctrl(cmd) && val_next[CTRL_CLR_BIT];

  rtc_nvram #(.DEPTH(RAM_DEPTH), .W(DAT_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(cmd[AW-1:0]),
    .wdata(val_next), .raddr(cmd[AW-1:0]), .rdata(ram_rd)
  );

  rtc_status_reg #(.W(DAT_W), .RESET_VAL(STATUS_RESET), .CLR_MASK(STATUS_CLR_MASK)) u_stat (
    .clk(clk), .rst_n(rst_n), .clr(ctrl_clr), .status_o(status), .irq_clr_o(irq2_clr)
  );

  assign rd_sel = rtc_read_sel(cmd, ram_rd, status, tfields);
  assign bidx   = BI_W'(PH_W'(FRAME_LEN - 1) - phase);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) ser_dout <= 1'b0;
    else if (take) begin
      if (phase >= PH_W'(CMD_W) && rd_sel.hit) ser_dout <= rd_sel.val[bidx];
      else                                     ser_dout <= 1'b0;
    end
  end

  a_r11_dout_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !ser_dout);

  a_r12_no_commit_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !(ram_we || ctrl_clr));

endmodule

// File: tb/rtc_serial_port_tb.sv
module rtc_serial_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] ctl = 3'b000;
  logic ser_dout, irq2_clr;
  logic [7:0] t_sec = 8'h59, t_min = 8'h07, t_hour = 8'h23;
  logic [7:0] t_mday = 8'h31, t_mon = 8'h12, t_year = 8'h99;
  int n_vec = 0, n_bad = 0;
  bit done = 0;
  byte unsigned exp_q[$];
  byte unsigned got_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  rtc_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_bits(ctl),
    .bcd_sec(t_sec), .bcd_min(t_min), .bcd_hour(t_hour),
    .bcd_mday(t_mday), .bcd_month(t_mon), .bcd_year(t_year),
    .ser_dout(ser_dout), .irq2_clr(irq2_clr)
  );

  function automatic byte unsigned ref_init(int i);
    return byte'(((i << 4) + i) % 256) ^ 8'b0101_1010;
  endfunction

  task automatic check(string tag, int got, int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // monitor: pop scoreboard entries and compare
  always @(negedge clk) begin
    if (got_q.size() > 0 && exp_q.size() > 0) begin
      check(tag_q.pop_front(), int'(got_q.pop_front()), int'(exp_q.pop_front()));
    end
  end

  task automatic put_bit(input logic b);
    ctl = {b, 1'b1, 1'b1}; @(negedge clk);
    ctl = {b, 1'b0, 1'b1}; @(negedge clk);
  endtask

  task automatic drop();
    ctl = 3'b000; @(negedge clk); @(negedge clk);
  endtask

  // full 16-bit frame; returns the byte seen on dout and whether dout was high early
  task automatic frame(input byte unsigned c, input byte unsigned d,
                       output byte unsigned got, output bit early_hi);
    early_hi = 0; got = 0;
    ctl = 3'b001; @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      put_bit(i < 8 ? c[7-i] : d[15-i]);
      if (i < 8) early_hi |= ser_dout;
      else       got[15-i] = ser_dout;
    end
  endtask

  task automatic rd(input byte unsigned c, input byte unsigned exp, input string tag);
    byte unsigned g; bit e;
    exp_q.push_back(exp); tag_q.push_back(tag);
    frame(c, 8'h00, g, e);
    got_q.push_back(g);
    drop();
  endtask

  task automatic wr(input byte unsigned c, input byte unsigned d);
    byte unsigned g; bit e;
    frame(c, d, g, e);
    drop();
  endtask

  initial begin
    byte unsigned g; bit e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 reset dout", int'(ser_dout), 0);
    check("R5 reset irq2_clr", int'(irq2_clr), 0);

    // R5 / R4: whole RAM image read serially
    for (int i = 0; i < 32; i++) rd(byte'(i), ref_init(i), $sformatf("R4 R5 ram[%0d]", i));

    // R6 status and fixed zero
    rd(8'h30, 8'h90, "R6 status reset");
    rd(8'h31, 8'h00, "R6 cmd 0x31");

    // R7 time fields
    rd(8'h20, t_sec,  "R7 seconds");
    rd(8'h21, t_min,  "R7 minutes");
    rd(8'h22, t_hour, "R7 hours");
    rd(8'h24, t_mday, "R7 mday");
    rd(8'h25, t_mon,  "R7 month");
    rd(8'h26, t_year, "R7 year");
    rd(8'h23, 8'h00,  "R7 unused 0x23");
    rd(8'h2F, 8'h00,  "R7 unused 0x2F");

    // R11: undefined code and early phases
    rd(8'h40, 8'h00, "R11 cmd 0x40");
    frame(8'h00, 8'h00, g, e); drop();
    check("R11 dout low in command phase", int'(e), 0);
    frame(8'h9F, 8'hFF, g, e); drop();
    check("R11 dout low on write", int'(g), 0);

    // R8 / R2 writes
    rd(8'h1F, 8'hFF, "R8 R2 write 0x9F");
    wr(8'h80, 8'h96);
    rd(8'h00, 8'h96, "R8 R2 write 0x80");

    // R1: edges with enable low take nothing; then a clean frame works
    for (int i = 0; i < 5; i++) begin
      ctl = 3'b110; @(negedge clk); ctl = 3'b100; @(negedge clk);
    end
    check("R1 dout with enable low", int'(ser_dout), 0);
    rd(8'h01, ref_init(1), "R1 frame after idle edges");

    // R3: partial write frame then abort
    ctl = 3'b001; @(negedge clk);
    for (int i = 0; i < 12; i++) put_bit(i < 8 ? 1'(8'h85 >> (7-i)) : 1'b1);
    drop();
    rd(8'h05, ref_init(5), "R3 partial frame discarded");
    wr(8'h85, 8'hC3);
    rd(8'h05, 8'hC3, "R3 next frame intact");

    // R10: extra edges after the 16th bit
    frame(8'h83, 8'hA5, g, e);
    for (int i = 0; i < 8; i++) put_bit(1'b1);
    drop();
    rd(8'h03, 8'hA5, "R10 extra edges ignored");

    // R12: abort in the same cycle as the 16th edge
    ctl = 3'b001; @(negedge clk);
    for (int i = 0; i < 15; i++) put_bit(i < 8 ? 1'(8'h84 >> (7-i)) : 1'(8'h3C >> (15-i)));
    ctl = 3'b011; @(negedge clk);
    ctl = 3'b000; @(negedge clk);
    check("R12 no pulse on abort", int'(irq2_clr), 0);
    drop();
    rd(8'h04, ref_init(4), "R12 abort beats commit");

    // R9: control write without and with bit 2
    frame(8'hB1, 8'h08, g, e);
    check("R9 no pulse without bit2", int'(irq2_clr), 0);
    drop();
    rd(8'h30, 8'h90, "R9 status kept");
    frame(8'hB1, 8'h04, g, e);
    check("R9 pulse high", int'(irq2_clr), 1);
    @(negedge clk);
    check("R9 pulse one cycle", int'(irq2_clr), 0);
    drop();
    rd(8'h30, 8'h80, "R9 status cleared");

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule